// File: doc/BRIEF.md
# PCI Bus Activity Monitor Counters

This block sits beside a PCI bus interface and only watches it. On every rising edge of the PCI clock it looks at the active-low bus control lines. It counts two kinds of cycle. The first kind is a cycle in which this device drives a transaction as initiator. The second kind is a cycle in which a data phase completes.

Each count passes through a private prescaler, so one step of a reported field stands for 64 qualifying clocks. The two 16-bit fields are reported together as one read-only 32-bit word. Software works out bus utilization from that word.

The two fields are coupled. When either field wraps back to zero, the other field is forced to zero, so the pair always describes the same measurement window. A software clear strobe starts a new window.

Top module: `pci_actmon`

## Requirements
- R1: The upper field `rd_data[31:16]` counts cycles where `mst_en` is 1 and `frame_n` is 0. Frame asserted without `mst_en` is not counted, and neither is `mst_en` with frame deasserted.
- R2: The lower field `rd_data[15:0]` counts cycles where `irdy_n` and `trdy_n` are both 0. Either line alone at 0 is not counted.
- R3: Each field steps by one once every 64 qualifying cycles. The running remainder is kept across non-qualifying cycles, and a field changes by at most one per clock.
- R4: In the cycle where the lower field wraps from 0xFFFF to 0, the upper field is forced to 0.
- R5: In the cycle where the upper field wraps from 0xFFFF to 0, the lower field is forced to 0.
- R6: A field that is forced to zero by the other field's wrap ends at 0, even if it would have stepped in that cycle. When both fields wrap in the same cycle, both end at 0.
- R7: A synchronous `rst` sets both fields and both prescalers to zero. So does a `sw_clr` pulse, and it wins over any qualifying activity in the same cycle.
- R8: `rd_data` comes straight from registers. It reflects every qualifying cycle sampled up to and including the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock; the bus lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Bus frame line, active low |
| irdy_n | input | 1 | Initiator-ready line, active low |
| trdy_n | input | 1 | Target-ready line, active low |
| mst_en | input | 1 | High while this device owns the bus as initiator |
| sw_clr | input | 1 | One-cycle software clear of both fields and prescalers |
| rd_data | output | 32 | {initiator-activity field, completed-transfer field} |

## Verification
Every result is due exactly one clock edge after the cycle whose inputs cause it. The counters are the only registers between the bus lines and `rd_data`.

The driver applies each cycle's inputs at the falling edge. It then updates a behavioural model built from the requirements and queues the expected word. The monitor removes one queued word per cycle and compares it 2 ns after the next rising edge, so each result is checked in its own cycle and no earlier.

Wrap and cross-clear cases need millions of cycles at full width. A second, narrow instance with a 2-bit prescaler and 4-bit fields runs the same stimulus and covers those cases in a few dozen cycles.

// File: rtl/pci_actmon_pkg.sv
package pci_actmon_pkg;

    // channel indices inside the monitor
    typedef enum int {
        CH_XFER = 0,
        CH_MST  = 1
    } chan_e;

    localparam int NUM_CH = 2;

    // per-cycle qualifying events decoded from the bus
    typedef struct packed {
        logic mst;   // initiator activity seen this clock
        logic xfer;  // completed data phase seen this clock
    } qual_t;

    function automatic qual_t decode_bus(input logic frame_n, input logic irdy_n,
                                         input logic trdy_n, input logic mst_en);
        qual_t q;
        q.mst  = mst_en & ~frame_n;
        q.xfer = ~irdy_n & ~trdy_n;
        return q;
    endfunction

endpackage

// File: rtl/actmon_qual.sv
module actmon_qual
    import pci_actmon_pkg::*;
(
    input  logic  frame_n,
    input  logic  irdy_n,
    input  logic  trdy_n,
    input  logic  mst_en,
    output qual_t qual_o
);
    // purely combinational; the counters sample it on the rising edge
    assign qual_o = decode_bus(frame_n, irdy_n, trdy_n, mst_en);
endmodule

// File: rtl/actmon_chan.sv
module actmon_chan #(
    parameter int PRE_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,   // software clear
    input  logic             inc_i,   // qualifying cycle
    input  logic             xclr_i,  // partner channel wraps this cycle
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o   // this channel wraps at the coming edge
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick   = inc_i && (&pre_q);
    assign wrap_o = tick && (&cnt_q);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            if (inc_i) pre_q <= pre_q + 1'b1;
            if (xclr_i)     cnt_q <= '0;
            else if (tick)  cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: a clear leaves field and prescaler at zero
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0 && pre_q == '0));

    // R3: with no activity and no clear, nothing moves
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !xclr_i && !inc_i) |=> ($stable(cnt_q) && $stable(pre_q)));

    // R3: the field moves by at most one per clock
    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !xclr_i) |=>
            (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R6: a partner wrap always leaves this field at zero
    p_xclr_zero_r6: assert property (@(posedge clk) disable iff (rst)
        xclr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pci_actmon.sv
module pci_actmon
    import pci_actmon_pkg::*;
#(
    parameter int PRE_W = 6,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic               trdy_n,
    input  logic               mst_en,
    input  logic               sw_clr,
    output logic [2*CNT_W-1:0] rd_data
);
    localparam int WORD_W = NUM_CH * CNT_W;

    qual_t                   qual;
    logic [NUM_CH-1:0]       inc;
    logic [NUM_CH-1:0]       wrap;
    logic [CNT_W-1:0]        cnt [NUM_CH];
    logic [WORD_W-1:0]       word;

    actmon_qual u_qual (
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .trdy_n  (trdy_n),
        .mst_en  (mst_en),
        .qual_o  (qual)
    );

    assign inc[CH_XFER] = qual.xfer;
    assign inc[CH_MST]  = qual.mst;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        actmon_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .clr_i  (sw_clr),
            .inc_i  (inc[g]),
            .xclr_i (wrap[NUM_CH-1-g]),
            .cnt_o  (cnt[g]),
            .wrap_o (wrap[g])
        );
        assign word[g*CNT_W +: CNT_W] = cnt[g];
    end

    assign rd_data = word;

    // R4: transfer wrap empties the initiator field
    p_xwrap_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (wrap[CH_XFER] && !sw_clr) |=> (rd_data[2*CNT_W-1:CNT_W] == '0));

    // R5: initiator wrap empties the transfer field
    p_mwrap_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (wrap[CH_MST] && !sw_clr) |=> (rd_data[CNT_W-1:0] == '0));

    // R1: initiator field frozen when not owning a frame
    p_mst_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ((!mst_en || frame_n) && !sw_clr && !wrap[CH_XFER])
            |=> $stable(rd_data[2*CNT_W-1:CNT_W]));

    // R2: transfer field frozen unless both ready lines are low
    p_xfer_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ((irdy_n || trdy_n) && !sw_clr && !wrap[CH_MST])
            |=> $stable(rd_data[CNT_W-1:0]));
endmodule

// File: tb/test_pci_actmon.sv
`timescale 1ns/1ps
module test_pci_actmon;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, mst_en = 1'b0, sw_clr = 1'b0;
    logic [31:0] rd_big;
    logic [7:0]  rd_sml;

    always #10 clk = ~clk; // 50 MHz

    pci_actmon i_pci_actmon (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .mst_en(mst_en), .sw_clr(sw_clr), .rd_data(rd_big)
    );

    // narrow copy so wraps happen within a few dozen cycles
    pci_actmon #(.PRE_W(2), .CNT_W(4)) i_pci_actmon_w (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .mst_en(mst_en), .sw_clr(sw_clr), .rd_data(rd_sml)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] q_big [$];
    logic [7:0]  q_sml [$];
    string       q_tag [$];

    int pm_b = 0, px_b = 0, cm_b = 0, cx_b = 0;
    int pm_s = 0, px_s = 0, cm_s = 0, cx_s = 0;

    function automatic void mstep(input int plim, input int clim,
                                  inout int pm, inout int px, inout int cm, inout int cx,
                                  input bit qm, input bit qx, input bit clr);
        bit wm, wx;
        if (clr) begin
            pm = 0; px = 0; cm = 0; cx = 0;
            return;
        end
        wm = qm && (pm == plim - 1) && (cm == clim - 1);
        wx = qx && (px == plim - 1) && (cx == clim - 1);
        if (qm) begin
            if (pm == plim - 1) cm = (cm + 1) % clim;
            pm = (pm + 1) % plim;
        end
        if (qx) begin
            if (px == plim - 1) cx = (cx + 1) % clim;
            px = (px + 1) % plim;
        end
        if (wx) cm = 0;
        if (wm) cx = 0;
    endfunction

    task automatic drive(input bit rs, input bit fr, input bit ir, input bit tr,
                         input bit ms, input bit cl, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rst = rs; frame_n = fr; irdy_n = ir; trdy_n = tr; mst_en = ms; sw_clr = cl;
            mstep(64, 65536, pm_b, px_b, cm_b, cx_b, ms && !fr, !ir && !tr, rs || cl);
            mstep(4, 16, pm_s, px_s, cm_s, cx_s, ms && !fr, !ir && !tr, rs || cl);
            q_big.push_back((32'(cm_b) << 16) | 32'(cx_b));
            q_sml.push_back((8'(cm_s) << 4) | 8'(cx_s));
            q_tag.push_back(tag);
        end
    endtask

    // monitor: one expected word per edge, compared just after the edge
    always @(posedge clk) begin
        #2;
        if (q_big.size() > 0 && !finished) begin
            logic [31:0] eb;
            logic [7:0]  es;
            string       t;
            eb = q_big.pop_front();
            es = q_sml.pop_front();
            t  = q_tag.pop_front();
            checks += 2;
            if (rd_big !== eb) begin
                errors++;
                $display("FAIL %s wide: got %h expected %h", t, rd_big, eb);
            end
            if (rd_sml !== es) begin
                errors++;
                $display("FAIL %s narrow: got %h expected %h", t, rd_sml, es);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R7 reset state
        drive(1, 1, 1, 1, 0, 0, 2, "R7 reset");
        // R1 negatives: frame without ownership, ownership without frame
        drive(0, 0, 1, 1, 0, 0, 70, "R1 frame w/o mst_en");
        drive(0, 1, 1, 1, 1, 0, 70, "R1 mst_en w/o frame");
        // R2 negatives: one ready line alone
        drive(0, 1, 0, 1, 0, 0, 70, "R2 irdy alone");
        drive(0, 1, 1, 0, 0, 0, 70, "R2 trdy alone");
        // R1 R3 initiator counting, prescale by 64
        drive(0, 0, 1, 1, 1, 0, 64, "R1 R3 initiator count");
        // R2 R3 transfer counting with gaps in between
        drive(0, 1, 0, 0, 0, 0, 30, "R2 R3 transfers");
        drive(0, 1, 1, 1, 0, 0, 10, "R3 remainder kept");
        drive(0, 1, 0, 0, 0, 0, 100, "R2 R3 transfers");
        // R8 mixed activity, both fields every cycle
        drive(0, 0, 0, 0, 1, 0, 100, "R8 R1 R2 mixed");
        // R7 clear beats activity, prescalers restart
        drive(0, 0, 0, 0, 1, 1, 1, "R7 clear vs activity");
        drive(0, 0, 0, 0, 1, 0, 64, "R7 R3 prescaler restarted");
        // R4 transfer wrap clears initiator field
        drive(0, 1, 1, 1, 0, 1, 1, "R7 clear");
        drive(0, 0, 1, 1, 1, 0, 8, "R4 setup");
        drive(0, 1, 0, 0, 0, 0, 64, "R4 transfer wrap");
        // R5 initiator wrap clears transfer field
        drive(0, 1, 1, 1, 0, 1, 1, "R7 clear");
        drive(0, 1, 0, 0, 0, 0, 8, "R5 setup");
        drive(0, 0, 1, 1, 1, 0, 64, "R5 initiator wrap");
        // R6 simultaneous wraps
        drive(0, 1, 1, 1, 0, 1, 1, "R7 clear");
        drive(0, 0, 0, 0, 1, 0, 64, "R6 both wrap");
        // R6 forced zero wins over a step
        drive(0, 1, 1, 1, 0, 1, 1, "R7 clear");
        drive(0, 1, 0, 0, 0, 0, 60, "R6 setup");
        drive(0, 0, 1, 1, 1, 0, 27, "R6 setup");
        drive(0, 1, 0, 0, 0, 0, 3, "R6 setup");
        drive(0, 0, 0, 0, 1, 0, 1, "R6 zero not one");
        drive(0, 1, 1, 1, 0, 0, 3, "R6 after");
        wait (q_big.size() == 0);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule